// File: doc/BRIEF.md
# Three-Channel Doorbell Mailbox

This block lets a local processor and a remote processor signal each other through three channels. Each channel holds a 32-bit status word, and every bit of that word works as a separate doorbell. Either processor can raise doorbell bits by writing ones to the channel's set register, and can lower them by writing ones to its clear register. Both can read the word back through its status register. Each channel drives one level interrupt that stays high while any bit of its word is set. A sender learns that its message has been consumed by polling the status word: the receiver clears the bits once it has read the data.

The two processors each reach the block through their own APB slave port. Both ports see the same 4 KiB register window and share one peripheral clock. The channels have fixed roles: channel 0 is the low-priority non-secure channel, channel 1 is the high-priority non-secure channel, and channel 2 is the secure channel. A non-secure transfer that targets channel 2 is refused.

Each port runs a two-state machine. In `PS_IDLE` the port waits for an access phase. The transition *accept* (psel and penable both high while idle) commits any write to the status words and captures the read data and error flag, then moves to `PS_RESP`. `PS_RESP` drives pready high for one cycle, and the transition *complete* then returns to `PS_IDLE`.

Top module: `mbx_doorbell_top`

## Requirements
- R1: After reset every status word is zero, all three interrupts are low, and neither port drives pready.
- R2: A write to a channel's set register (offset 0x08) ORs the written data into that channel's status word. Data bits written as zero leave their status bits unchanged. A read of the status register (offset 0x00) returns the current word.
- R3: A write to a channel's clear register (offset 0x10) clears every status bit written as one and leaves the others unchanged.
- R4: Interrupt outputs are active-high registered levels that change on the same clock edge as the status word. irq_lp follows channel 0, irq_hp follows channel 1 and irq_sec follows channel 2. Each is high exactly while its channel's word is non-zero, and a partial clear keeps it high.
- R5: When both ports set bits in the same channel on the same clock edge, the union of both writes is applied.
- R6: When a set and a clear reach the same bit on the same clock edge, from either port, the bit ends cleared.
- R7: A non-secure transfer (pprot bit 1 high) to any register of channel 2 returns read data zero and pslverr high, and any write it carries is discarded. A secure transfer (pprot bit 1 low) to channel 2 works normally and has pslverr low.
- R8: Channel bases are 0x000, 0x020 and 0x200, with register offsets STAT 0x00, SET 0x08 and CLEAR 0x10. Writes to STAT are ignored. Reads of SET and CLEAR return zero. Any other address reads zero, ignores writes and has pslverr low.
- R9: Every transfer takes one wait state. pready is low in the first access cycle and high in the second, and it is never high on two consecutive cycles.
- R10: Non-secure transfers to channels 0 and 1 are accepted with pslverr low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Peripheral clock shared by both ports |
| presetn | input | 1 | Active-low asynchronous reset |
| lcl_psel | input | 1 | Local port select |
| lcl_penable | input | 1 | Local port access phase |
| lcl_pwrite | input | 1 | Local port write (1) or read (0) |
| lcl_paddr | input | 12 | Local port byte address |
| lcl_pwdata | input | 32 | Local port write data |
| lcl_pprot | input | 3 | Local port protection; bit 1 high marks non-secure |
| lcl_prdata | output | 32 | Local port read data |
| lcl_pready | output | 1 | Local port transfer complete |
| lcl_pslverr | output | 1 | Local port error response |
| rmt_psel | input | 1 | Remote port select |
| rmt_penable | input | 1 | Remote port access phase |
| rmt_pwrite | input | 1 | Remote port write (1) or read (0) |
| rmt_paddr | input | 12 | Remote port byte address |
| rmt_pwdata | input | 32 | Remote port write data |
| rmt_pprot | input | 3 | Remote port protection; bit 1 high marks non-secure |
| rmt_prdata | output | 32 | Remote port read data |
| rmt_pready | output | 1 | Remote port transfer complete |
| rmt_pslverr | output | 1 | Remote port error response |
| irq_lp | output | 1 | Channel 0 (low-priority) interrupt level |
| irq_hp | output | 1 | Channel 1 (high-priority) interrupt level |
| irq_sec | output | 1 | Channel 2 (secure) interrupt level |

## Verification
The two ports can update one status word on the same edge. The case that matters is a set from one side meeting a clear from the other, and two sets landing together. The bench starts both ports' transfers inside one fork, so that their access phases line up cycle for cycle. It then reads the status word back and compares it with the old word ORed with both set masks, minus every bit named by the clear. A bit that was both set and cleared must read zero, and bits named by only one of the writes must show that write's effect.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MBX_NCH    = 3;
    localparam int MBX_DW     = 32;
    localparam int MBX_AW     = 12;
    localparam int MBX_CHW    = $clog2(MBX_NCH);
    localparam int MBX_SEC_CH = MBX_NCH - 1;

    localparam logic [4:0] OFS_STAT = 5'h00;
    localparam logic [4:0] OFS_SET  = 5'h08;
    localparam logic [4:0] OFS_CLR  = 5'h10;

    localparam logic [MBX_AW-1:0] CH_BASE [MBX_NCH] = '{12'h000, 12'h020, 12'h200};

    typedef enum logic [1:0] {
        RK_NONE,
        RK_STAT,
        RK_SET,
        RK_CLR
    } reg_kind_e;

    typedef enum logic {
        PS_IDLE,
        PS_RESP
    } port_state_e;

    typedef struct packed {
        logic                 hit;
        logic [MBX_CHW-1:0]   ch;
        reg_kind_e            kind;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [MBX_AW-1:0] a);
        reg_dec_t  r;
        reg_kind_e k;
        r.hit  = 1'b0;
        r.ch   = '0;
        r.kind = RK_NONE;
        for (int c = 0; c < MBX_NCH; c++) begin
            if (a[MBX_AW-1:5] == CH_BASE[c][MBX_AW-1:5]) begin
                case (a[4:0])
                    OFS_STAT: k = RK_STAT;
                    OFS_SET:  k = RK_SET;
                    OFS_CLR:  k = RK_CLR;
                    default:  k = RK_NONE;
                endcase
                if (k != RK_NONE) begin
                    r.hit  = 1'b1;
                    r.ch   = c[MBX_CHW-1:0];
                    r.kind = k;
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int DW = MBX_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_a,
    input  logic [DW-1:0] set_b,
    input  logic [DW-1:0] clr_a,
    input  logic [DW-1:0] clr_b,
    output logic [DW-1:0] stat_o,
    output logic          irq_o
);

    logic [DW-1:0] stat_q;
    logic [DW-1:0] stat_d;
    logic [DW-1:0] set_all;
    logic [DW-1:0] clr_all;
    logic          irq_q;

    assign set_all = set_a | set_b;
    assign clr_all = clr_a | clr_b;

    // Clear is applied after set, so a bit named by both ends low.
    assign stat_d = (stat_q | set_all) & ~clr_all;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            irq_q  <= |stat_d;
        end
    end

    assign stat_o = stat_q;
    assign irq_o  = irq_q;

    // R6: a bit hit by both a set and a clear is low afterwards
    p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_all & clr_all) != '0) |=> ((stat_q & $past(set_all & clr_all)) == '0));

    // R2: bits set without a competing clear are high afterwards
    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_all & ~clr_all) != '0) |=>
            ((stat_q & $past(set_all & ~clr_all)) == $past(set_all & ~clr_all)));

    // R3: with no set or clear, the word holds
    p_word_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_all | clr_all) == '0) |=> $stable(stat_q));

endmodule

// File: rtl/mbx_apb_port.sv
module mbx_apb_port
    import mbx_pkg::*;
#(
    parameter int NCH    = MBX_NCH,
    parameter int DW     = MBX_DW,
    parameter int AW     = MBX_AW,
    parameter int SEC_CH = MBX_SEC_CH
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   psel,
    input  logic                   penable,
    input  logic                   pwrite,
    input  logic [AW-1:0]          paddr,
    input  logic [DW-1:0]          pwdata,
    input  logic [2:0]             pprot,
    input  logic [NCH-1:0][DW-1:0] stat_i,
    output logic [DW-1:0]          prdata,
    output logic                   pready,
    output logic                   pslverr,
    output logic [NCH-1:0][DW-1:0] set_o,
    output logic [NCH-1:0][DW-1:0] clr_o
);

    port_state_e   state_q;
    port_state_e   state_d;
    reg_dec_t      dec;
    logic          accept;
    logic          sec_block;
    logic [DW-1:0] rd_val;
    logic [DW-1:0] rdata_q;
    logic          err_q;
    logic          unused_prot;

    assign unused_prot = ^{pprot[2], pprot[0]};

    assign dec       = decode_addr(paddr);
    assign accept    = (state_q == PS_IDLE) && psel && penable;
    assign sec_block = dec.hit && (int'(dec.ch) == SEC_CH) && pprot[1];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: if (accept) state_d = PS_RESP;
            PS_RESP: state_d = PS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // Read data selection
    always_comb begin
        rd_val = '0;
        if (dec.hit && dec.kind == RK_STAT && !sec_block) begin
            rd_val = stat_i[dec.ch];
        end
    end

    // Response registers, captured on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (accept) begin
            rdata_q <= pwrite ? '0 : rd_val;
            err_q   <= sec_block;
        end
    end

    // Outputs
    always_comb begin
        pready  = 1'b0;
        prdata  = '0;
        pslverr = 1'b0;
        unique case (state_q)
            PS_IDLE: ;
            PS_RESP: begin
                pready  = 1'b1;
                prdata  = rdata_q;
                pslverr = err_q;
            end
        endcase
    end

    // Per-channel write strobes
    for (genvar c = 0; c < NCH; c++) begin : g_mask
        logic wr_here;
        assign wr_here  = accept && pwrite && dec.hit && !sec_block && (int'(dec.ch) == c);
        assign set_o[c] = (wr_here && dec.kind == RK_SET) ? pwdata : '0;
        assign clr_o[c] = (wr_here && dec.kind == RK_CLR) ? pwdata : '0;
    end

    // R9: pready is a one-cycle pulse
    p_one_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pready |=> !pready);

    // R7: a refused secure access answers with an error and zero data
    p_sec_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec.hit && int'(dec.ch) == SEC_CH && pprot[1]) |=>
            (pready && pslverr && prdata == '0));

endmodule

// File: rtl/mbx_doorbell_top.sv
module mbx_doorbell_top
    import mbx_pkg::*;
#(
    parameter int DW = MBX_DW,
    parameter int AW = MBX_AW
) (
    input  logic          pclk,
    input  logic          presetn,
    input  logic          lcl_psel,
    input  logic          lcl_penable,
    input  logic          lcl_pwrite,
    input  logic [AW-1:0] lcl_paddr,
    input  logic [DW-1:0] lcl_pwdata,
    input  logic [2:0]    lcl_pprot,
    output logic [DW-1:0] lcl_prdata,
    output logic          lcl_pready,
    output logic          lcl_pslverr,
    input  logic          rmt_psel,
    input  logic          rmt_penable,
    input  logic          rmt_pwrite,
    input  logic [AW-1:0] rmt_paddr,
    input  logic [DW-1:0] rmt_pwdata,
    input  logic [2:0]    rmt_pprot,
    output logic [DW-1:0] rmt_prdata,
    output logic          rmt_pready,
    output logic          rmt_pslverr,
    output logic          irq_lp,
    output logic          irq_hp,
    output logic          irq_sec
);

    localparam int NCH = MBX_NCH;

    logic [NCH-1:0][DW-1:0] stat_w;
    logic [NCH-1:0][DW-1:0] lcl_set;
    logic [NCH-1:0][DW-1:0] lcl_clr;
    logic [NCH-1:0][DW-1:0] rmt_set;
    logic [NCH-1:0][DW-1:0] rmt_clr;
    logic [NCH-1:0]         irq_w;

    mbx_apb_port #(.NCH(NCH), .DW(DW), .AW(AW), .SEC_CH(MBX_SEC_CH)) u_lcl (
        .clk     (pclk),
        .rst_n   (presetn),
        .psel    (lcl_psel),
        .penable (lcl_penable),
        .pwrite  (lcl_pwrite),
        .paddr   (lcl_paddr),
        .pwdata  (lcl_pwdata),
        .pprot   (lcl_pprot),
        .stat_i  (stat_w),
        .prdata  (lcl_prdata),
        .pready  (lcl_pready),
        .pslverr (lcl_pslverr),
        .set_o   (lcl_set),
        .clr_o   (lcl_clr)
    );

    mbx_apb_port #(.NCH(NCH), .DW(DW), .AW(AW), .SEC_CH(MBX_SEC_CH)) u_rmt (
        .clk     (pclk),
        .rst_n   (presetn),
        .psel    (rmt_psel),
        .penable (rmt_penable),
        .pwrite  (rmt_pwrite),
        .paddr   (rmt_paddr),
        .pwdata  (rmt_pwdata),
        .pprot   (rmt_pprot),
        .stat_i  (stat_w),
        .prdata  (rmt_prdata),
        .pready  (rmt_pready),
        .pslverr (rmt_pslverr),
        .set_o   (rmt_set),
        .clr_o   (rmt_clr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        mbx_channel #(.DW(DW)) u_ch (
            .clk    (pclk),
            .rst_n  (presetn),
            .set_a  (lcl_set[c]),
            .set_b  (rmt_set[c]),
            .clr_a  (lcl_clr[c]),
            .clr_b  (rmt_clr[c]),
            .stat_o (stat_w[c]),
            .irq_o  (irq_w[c])
        );
    end

    // R4: fixed interrupt order, low-priority, high-priority, secure
    assign irq_lp  = irq_w[0];
    assign irq_hp  = irq_w[1];
    assign irq_sec = irq_w[2];

endmodule

// File: tb/tb_mbx_doorbell_top.sv
module tb_mbx_doorbell_top;

    localparam logic [2:0] NS  = 3'b010;
    localparam logic [2:0] SEC = 3'b000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel [2];
    logic        penable [2];
    logic        pwrite [2];
    logic [11:0] paddr [2];
    logic [31:0] pwdata [2];
    logic [2:0]  pprot [2];
    logic [31:0] prdata [2];
    logic        pready [2];
    logic        pslverr [2];
    logic        irq_lp, irq_hp, irq_sec;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mbx_doorbell_top dut (
        .pclk(clk), .presetn(rst_n),
        .lcl_psel(psel[0]), .lcl_penable(penable[0]), .lcl_pwrite(pwrite[0]),
        .lcl_paddr(paddr[0]), .lcl_pwdata(pwdata[0]), .lcl_pprot(pprot[0]),
        .lcl_prdata(prdata[0]), .lcl_pready(pready[0]), .lcl_pslverr(pslverr[0]),
        .rmt_psel(psel[1]), .rmt_penable(penable[1]), .rmt_pwrite(pwrite[1]),
        .rmt_paddr(paddr[1]), .rmt_pwdata(pwdata[1]), .rmt_pprot(pprot[1]),
        .rmt_prdata(prdata[1]), .rmt_pready(pready[1]), .rmt_pslverr(pslverr[1]),
        .irq_lp(irq_lp), .irq_hp(irq_hp), .irq_sec(irq_sec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input int p, input logic wr, input logic [11:0] a,
                        input logic [31:0] d, input logic [2:0] prot,
                        output logic [31:0] rd, output logic er,
                        output logic rdy0, output logic rdy1);
        @(negedge clk);
        psel[p] = 1'b1; penable[p] = 1'b0; pwrite[p] = wr;
        paddr[p] = a; pwdata[p] = d; pprot[p] = prot;
        @(negedge clk);
        penable[p] = 1'b1;
        rdy0 = pready[p];
        @(negedge clk);
        rdy1 = pready[p]; rd = prdata[p]; er = pslverr[p];
        @(negedge clk);
        psel[p] = 1'b0; penable[p] = 1'b0;
    endtask

    task automatic wr(input int p, input logic [11:0] a, input logic [31:0] d,
                      input logic [2:0] prot, output logic er);
        logic [31:0] rd; logic r0, r1;
        xfer(p, 1'b1, a, d, prot, rd, er, r0, r1);
    endtask

    task automatic rd(input int p, input logic [11:0] a, input logic [2:0] prot,
                      output logic [31:0] d, output logic er);
        logic r0, r1;
        xfer(p, 1'b0, a, 32'h0, prot, d, er, r0, r1);
    endtask

    task automatic t_reset();
        logic [31:0] d; logic e;
        chk("R1 irq_lp", {31'b0, irq_lp}, 32'h0);
        chk("R1 irq_hp", {31'b0, irq_hp}, 32'h0);
        chk("R1 irq_sec", {31'b0, irq_sec}, 32'h0);
        chk("R1 pready", {30'b0, pready[1], pready[0]}, 32'h0);
        rd(0, 12'h000, NS, d, e);
        chk("R1 stat ch0", d, 32'h0);
    endtask

    task automatic t_set_and_timing();
        logic [31:0] d; logic e, r0, r1;
        xfer(0, 1'b1, 12'h008, 32'h0000_00A5, NS, d, e, r0, r1);
        chk("R9 pready low first access cycle", {31'b0, r0}, 32'h0);
        chk("R9 pready high second cycle", {31'b0, r1}, 32'h1);
        chk("R10 no error ch0", {31'b0, e}, 32'h0);
        rd(0, 12'h000, NS, d, e);
        chk("R2 stat after set", d, 32'h0000_00A5);
        wr(0, 12'h008, 32'h0, NS, e);
        rd(1, 12'h000, NS, d, e);
        chk("R2 zero set no effect", d, 32'h0000_00A5);
        wr(1, 12'h008, 32'h0000_0100, NS, e);
        rd(0, 12'h000, NS, d, e);
        chk("R2 set ORs", d, 32'h0000_01A5);
    endtask

    task automatic t_clear_irq();
        logic [31:0] d; logic e;
        chk("R4 irq_lp high", {31'b0, irq_lp}, 32'h1);
        chk("R4 irq_hp low", {31'b0, irq_hp}, 32'h0);
        wr(1, 12'h010, 32'h0000_0005, NS, e);
        rd(0, 12'h000, NS, d, e);
        chk("R3 clear ones only", d, 32'h0000_01A0);
        wr(1, 12'h010, 32'h0, NS, e);
        rd(0, 12'h000, NS, d, e);
        chk("R3 zero clear no effect", d, 32'h0000_01A0);
        chk("R4 irq_lp after partial clear", {31'b0, irq_lp}, 32'h1);
        wr(0, 12'h010, 32'h0000_01A0, NS, e);
        chk("R4 irq_lp low once empty", {31'b0, irq_lp}, 32'h0);
        wr(1, 12'h028, 32'h8000_0003, NS, e);
        chk("R10 no error ch1", {31'b0, e}, 32'h0);
        chk("R4 irq_hp high", {31'b0, irq_hp}, 32'h1);
        chk("R4 irq_lp stays low", {31'b0, irq_lp}, 32'h0);
        wr(0, 12'h030, 32'h8000_0000, NS, e);
        chk("R4 irq_hp after partial clear", {31'b0, irq_hp}, 32'h1);
        wr(0, 12'h030, 32'h0000_0003, NS, e);
        chk("R4 irq_hp low once empty", {31'b0, irq_hp}, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] d; logic e;
        wr(0, 12'h020, 32'hFFFF_FFFF, NS, e);
        rd(0, 12'h020, NS, d, e);
        chk("R8 stat write ignored", d, 32'h0);
        wr(0, 12'h028, 32'h0000_0040, NS, e);
        rd(0, 12'h028, NS, d, e);
        chk("R8 set reads zero", d, 32'h0);
        rd(0, 12'h030, NS, d, e);
        chk("R8 clear reads zero", d, 32'h0);
        rd(1, 12'h020, NS, d, e);
        chk("R8 ch1 base", d, 32'h0000_0040);
        rd(0, 12'h040, NS, d, e);
        chk("R8 unmapped reads zero", d, 32'h0);
        chk("R8 unmapped no error", {31'b0, e}, 32'h0);
        wr(0, 12'h024, 32'hFFFF_FFFF, NS, e);
        rd(0, 12'h020, NS, d, e);
        chk("R8 unmapped write ignored", d, 32'h0000_0040);
        wr(0, 12'h030, 32'h0000_0040, NS, e);
    endtask

    task automatic t_secure();
        logic [31:0] d; logic e;
        wr(1, 12'h208, 32'h0000_0011, SEC, e);
        chk("R7 secure write ok", {31'b0, e}, 32'h0);
        chk("R4 irq_sec high", {31'b0, irq_sec}, 32'h1);
        rd(0, 12'h200, SEC, d, e);
        chk("R7 secure read", d, 32'h0000_0011);
        rd(0, 12'h200, NS, d, e);
        chk("R7 ns read zero", d, 32'h0);
        chk("R7 ns read error", {31'b0, e}, 32'h1);
        wr(0, 12'h210, 32'h0000_0011, NS, e);
        chk("R7 ns clear error", {31'b0, e}, 32'h1);
        wr(1, 12'h208, 32'h0000_0100, NS, e);
        chk("R7 ns set error", {31'b0, e}, 32'h1);
        rd(1, 12'h200, SEC, d, e);
        chk("R7 ns writes ignored", d, 32'h0000_0011);
        wr(0, 12'h210, 32'h0000_0011, SEC, e);
        chk("R4 irq_sec low", {31'b0, irq_sec}, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d0, d1, d; logic e0, e1, a0, a1, b0, b1, e;
        fork
            xfer(0, 1'b1, 12'h008, 32'h0000_000F, NS, d0, e0, a0, a1);
            xfer(1, 1'b1, 12'h008, 32'h0000_00F0, NS, d1, e1, b0, b1);
        join
        rd(0, 12'h000, NS, d, e);
        chk("R5 both sets applied", d, 32'h0000_00FF);
        fork
            xfer(0, 1'b1, 12'h008, 32'h0000_0300, NS, d0, e0, a0, a1);
            xfer(1, 1'b1, 12'h010, 32'h0000_0101, NS, d1, e1, b0, b1);
        join
        rd(1, 12'h000, NS, d, e);
        chk("R6 clear wins on shared bit", d, 32'h0000_02FE);
    endtask

    initial begin
        for (int p = 0; p < 2; p++) begin
            psel[p] = 1'b0; penable[p] = 1'b0; pwrite[p] = 1'b0;
            paddr[p] = '0; pwdata[p] = '0; pprot[p] = NS;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set_and_timing();
        t_clear_irq();
        t_map();
        t_secure();
        t_same_cycle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule